// File: doc/BRIEF.md
# Scan-Chain Debug Register Access Port

This block is a debug data register that sits behind a JTAG TAP controller. It gives a debugger serial access to a small file of debug registers. The debugger shifts a 38-bit frame through it. The frame holds a 32-bit data word, a 5-bit register address and a direction flag. On the update strobe, a write frame stores the data word in the addressed register, cut to that register's width. Every frame, read or write, also latches its address.

Reads are pipelined. On the next capture strobe, the register selected by the latched address is loaded into the data field. Its value therefore leaves on TDO during the following scan. Capturing the comms data register counts as the debugger consuming that word, and a one-cycle strobe reports it. Capturing the comms control register has no side effect, so a debugger ends a burst of reads with that address latched. A one-cycle write strobe, with the address and the truncated data, tells the logic behind the port that a register was written. Bit 4 of debug control comes out as the monitor-mode enable.

Top module: `dbgScanPort`

## Requirements
- R1: After reset (trstN low) every stored register is zero, the latched address is 0 (debug control), tdo is 0, and wrStb, commsConsume and monitorEn are 0.
- R2: The frame is 38 bits and shifts LSB first from tdi toward tdo, with the data field nearest tdo. Data is in bits 31:0, the address in bits 36:32 and the direction flag in bit 37. Each tck edge with shiftDr high moves the frame one bit. tdo always shows bit 0 of the shift stage. With none of the strobes high, tdo does not change.
- R3: On an update with the direction flag at 1, the addressed register takes the data field ANDed with a mask of its width. On the next cycle, wrStb is high for exactly one cycle, with wrAddr holding the address and wrData holding the truncated data.
- R4: Every update latches the frame's address. The next capture loads the value of that register into bits 31:0 of the shift stage and clears bits 37:32, so read data leaves on tdo in the scan after the one that named the address.
- R5: The address map and widths are: 0 debug control (6 bits), 1 debug status (5), 2 vector catch (8), 4 comms control (6), 5 comms data (32). Watchpoint 0 uses addresses 8 to 13: address value, address mask, data value and data mask (32 bits each), then control value (9) and control mask (8). Watchpoint 1 uses addresses 16 to 21 with the same order and widths.
- R6: The unlisted addresses (3, 6, 7, 14, 15 and 22 to 31) read as zero and drop writes. Bits above a register's width always read as zero.
- R7: Address 1 reads the coreStatus input zero-extended. A write frame to address 1 stores nothing there.
- R8: A capture with latched address 5 pulses commsConsume high for exactly the cycle after the capture edge. A capture with any other latched address leaves commsConsume low.
- R9: monitorEn equals bit 4 of the debug control register.
- R10: An update with the direction flag at 0 changes no register and raises no wrStb, whatever is in the data field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous reset, active low |
| captureDr | input | 1 | TAP in capture state for this register |
| shiftDr | input | 1 | TAP in shift state for this register |
| updateDr | input | 1 | TAP in update state for this register |
| tdi | input | 1 | Serial data in |
| coreStatus | input | 5 | Live core status bits, read at address 1 |
| tdo | output | 1 | Serial data out, bit 0 of the shift stage |
| monitorEn | output | 1 | Monitor-mode enable, bit 4 of debug control |
| wrStb | output | 1 | One-cycle pulse after a write update |
| wrAddr | output | 5 | Address of the last write frame |
| wrData | output | 32 | Truncated data of the last write frame |
| commsConsume | output | 1 | One-cycle pulse after comms data is captured |

## Verification
The bench builds the block with its default parameters: a 32-bit data field, a 5-bit address and so 32 addresses. At these values, the whole address space can be swept with one write frame and one read frame per address. The sweep covers every listed register width, every unlisted address and the read-only status slot. Each read value is checked one scan after the frame that named its address, so the pipelining, the drop of data carried by read frames, and the consume pulse on exactly one address are all checked across the full map. Separate scans set and clear the monitor-mode bit and change the core status between reads.

// File: rtl/dbgScanPkg.sv
package dbgScanPkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int STATUS_W = 5;
  localparam int FRAME_W  = DATA_W + ADDR_W + 1;
  localparam int NUM_REGS = 1 << ADDR_W;

  localparam int ADDR_DBG_CTRL   = 0;
  localparam int ADDR_DBG_STATUS = 1;
  localparam int ADDR_COMMS_DATA = 5;
  localparam int MON_BIT         = 4;

  typedef struct packed {
    logic loadCap;
    logic shiftEn;
    logic commitWr;
    logic commitAddr;
  } scanCtl_t;

  function automatic int regWidth(input int a);
    case (a)
      0:                               return 6;
      1:                               return STATUS_W;
      2:                               return 8;
      4:                               return 6;
      5:                               return DATA_W;
      8, 9, 10, 11, 16, 17, 18, 19:    return DATA_W;
      12, 20:                          return 9;
      13, 21:                          return 8;
      default:                         return 0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] maskOf(input int a);
    int w;
    w = regWidth(a);
    if (w >= DATA_W) return '1;
    return (DATA_W'(1) << w) - DATA_W'(1);
  endfunction
endpackage

// File: rtl/dbgScanCtl.sv
module dbgScanCtl
  import dbgScanPkg::*;
(
  input  logic     tck,
  input  logic     trstN,
  input  logic     captureDr,
  input  logic     shiftDr,
  input  logic     updateDr,
  input  logic     frameDir,
  output scanCtl_t ctl
);
  always_comb begin
    ctl.loadCap    = captureDr;
    ctl.shiftEn    = shiftDr && !captureDr;
    ctl.commitWr   = updateDr && frameDir;
    ctl.commitAddr = updateDr;
  end

  // R2: the TAP never asserts two of its strobes at once
  assert_one_strobe_R2: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({captureDr, shiftDr, updateDr}));
endmodule

// File: rtl/dbgScanData.sv
module dbgScanData
  import dbgScanPkg::*;
(
  input  logic                tck,
  input  logic                trstN,
  input  scanCtl_t            ctl,
  input  logic                tdi,
  input  logic [STATUS_W-1:0] coreStatus,
  output logic                tdo,
  output logic                frameDir,
  output logic                monitorEn,
  output logic                wrStb,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wrData,
  output logic                commsConsume
);
  logic [FRAME_W-1:0] shiftQ;
  logic [ADDR_W-1:0]  latchAddrQ;
  logic [DATA_W-1:0]  frameData;
  logic [ADDR_W-1:0]  frameAddr;
  logic [DATA_W-1:0]  rdVal [NUM_REGS];

  assign frameData = shiftQ[DATA_W-1:0];
  assign frameAddr = shiftQ[DATA_W +: ADDR_W];
  assign frameDir  = shiftQ[FRAME_W-1];
  assign tdo       = shiftQ[0];

  // Register file: one generated slot per address
  for (genvar a = 0; a < NUM_REGS; a++) begin : g_slot
    if (a == ADDR_DBG_STATUS) begin : g_status
      assign rdVal[a] = DATA_W'(coreStatus);
    end else if (regWidth(a) > 0) begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge tck or negedge trstN) begin
        if (!trstN) q <= '0;
        else if (ctl.commitWr && frameAddr == ADDR_W'(a)) q <= frameData & maskOf(a);
      end
      assign rdVal[a] = q;
    end else begin : g_empty
      assign rdVal[a] = '0;
    end
  end

  assign monitorEn = rdVal[ADDR_DBG_CTRL][MON_BIT];

  // Shift stage and address latch
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      shiftQ     <= '0;
      latchAddrQ <= '0;
    end else begin
      if (ctl.loadCap)      shiftQ <= {{(ADDR_W + 1){1'b0}}, rdVal[latchAddrQ]};
      else if (ctl.shiftEn) shiftQ <= {tdi, shiftQ[FRAME_W-1:1]};
      if (ctl.commitAddr)   latchAddrQ <= frameAddr;
    end
  end

  // Strobes towards the register file owner
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      wrStb        <= 1'b0;
      wrAddr       <= '0;
      wrData       <= '0;
      commsConsume <= 1'b0;
    end else begin
      wrStb        <= ctl.commitWr;
      commsConsume <= ctl.loadCap && latchAddrQ == ADDR_W'(ADDR_COMMS_DATA);
      if (ctl.commitWr) begin
        wrAddr <= frameAddr;
        wrData <= frameData & maskOf(int'(frameAddr));
      end
    end
  end

  // R6: reported write data never carries bits above the register width
  assert_wr_trunc_R6: assert property (@(posedge tck) disable iff (!trstN)
    wrStb |-> (wrData & ~maskOf(int'(wrAddr))) == '0);

  // R8: consume pulse only with the comms data address latched
  assert_consume_addr_R8: assert property (@(posedge tck) disable iff (!trstN)
    commsConsume |-> latchAddrQ == ADDR_W'(ADDR_COMMS_DATA));

  // R2: tdo holds while neither capturing nor shifting
  assert_tdo_hold_R2: assert property (@(posedge tck) disable iff (!trstN)
    (!ctl.loadCap && !ctl.shiftEn) |=> $stable(tdo));

  // R9: monitor enable moves only with a write to debug control
  assert_monitor_wr_R9: assert property (@(posedge tck) disable iff (!trstN)
    !$stable(monitorEn) |-> (wrStb && wrAddr == ADDR_W'(ADDR_DBG_CTRL)));

  // R3: the write pulse lasts one cycle
  assert_wr_pulse_R3: assert property (@(posedge tck) disable iff (!trstN)
    wrStb |=> !wrStb);
endmodule

// File: rtl/dbgScanPort.sv
module dbgScanPort
  import dbgScanPkg::*;
(
  input  logic                tck,
  input  logic                trstN,
  input  logic                captureDr,
  input  logic                shiftDr,
  input  logic                updateDr,
  input  logic                tdi,
  input  logic [STATUS_W-1:0] coreStatus,
  output logic                tdo,
  output logic                monitorEn,
  output logic                wrStb,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wrData,
  output logic                commsConsume
);
  scanCtl_t ctl;
  logic     frameDir;

  dbgScanCtl i_ctl (
    .tck       (tck),
    .trstN     (trstN),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .frameDir  (frameDir),
    .ctl       (ctl)
  );

  dbgScanData i_data (
    .tck          (tck),
    .trstN        (trstN),
    .ctl          (ctl),
    .tdi          (tdi),
    .coreStatus   (coreStatus),
    .tdo          (tdo),
    .frameDir     (frameDir),
    .monitorEn    (monitorEn),
    .wrStb        (wrStb),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .commsConsume (commsConsume)
  );
endmodule

// File: tb/test_dbgScanPort.sv
`timescale 1ns/1ps
module test_dbgScanPort;
  logic        tck = 1'b0;
  logic        trstN = 1'b0;
  logic        captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic [4:0]  coreStatus = 5'h0B;
  logic        tdo, monitorEn, wrStb, commsConsume;
  logic [4:0]  wrAddr;
  logic [31:0] wrData;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #4 tck = ~tck;

  dbgScanPort i_dbgScanPort (
    .tck(tck), .trstN(trstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .tdi(tdi), .coreStatus(coreStatus), .tdo(tdo),
    .monitorEn(monitorEn), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .commsConsume(commsConsume)
  );

  // Results of the last scan
  logic [37:0] capBits;
  logic        consumeSeen, wrSeen, monSeen;
  logic [4:0]  wrASeen;
  logic [31:0] wrDSeen;

  function automatic int expWidth(input int a);
    if (a == 0 || a == 4) return 6;
    if (a == 1) return 5;
    if (a == 2) return 8;
    if (a == 5) return 32;
    if ((a >= 8 && a <= 11) || (a >= 16 && a <= 19)) return 32;
    if (a == 12 || a == 20) return 9;
    if (a == 13 || a == 21) return 8;
    return 0;
  endfunction

  function automatic logic [31:0] expMask(input int a);
    int w = expWidth(a);
    if (w == 32) return 32'hFFFF_FFFF;
    return (32'd1 << w) - 32'd1;
  endfunction

  function automatic logic [31:0] pat(input int a);
    return 32'h9E37_79B9 * 32'(a + 1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(input string req, input logic [37:0] act, input logic [37:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scan(input logic dir, input logic [4:0] addr, input logic [31:0] data);
    logic [37:0] frame;
    frame = {dir, addr, data};
    captureDr = 1'b1;
    @(negedge tck);
    captureDr = 1'b0;
    consumeSeen = commsConsume;
    for (int i = 0; i < 38; i++) begin
      capBits[i] = tdo;
      tdi = frame[i];
      shiftDr = 1'b1;
      @(negedge tck);
    end
    shiftDr = 1'b0;
    updateDr = 1'b1;
    @(negedge tck);
    updateDr = 1'b0;
    wrSeen  = wrStb;
    wrASeen = wrAddr;
    wrDSeen = wrData;
    monSeen = monitorEn;
    @(negedge tck);
  endtask

  initial begin
    repeat (3) @(negedge tck);
    // R1: reset state
    check("R1 tdo", 38'(tdo), 38'd0);
    check("R1 monitorEn", 38'(monitorEn), 38'd0);
    check("R1 wrStb", 38'(wrStb), 38'd0);
    check("R1 commsConsume", 38'(commsConsume), 38'd0);
    trstN = 1'b1;
    @(negedge tck);
    // R1/R4: first capture reads debug control (latched address 0) as zero
    scan(1'b0, 5'd4, 32'h0);
    check("R1 first capture", capBits, 38'd0);
    check("R10 read frame no wrStb", 38'(wrSeen), 38'd0);

    // R3/R5/R6: write sweep over all addresses
    for (int a = 0; a < 32; a++) begin
      scan(1'b1, 5'(a), pat(a));
      check("R3 wrStb", 38'(wrSeen), 38'd1);
      check("R3 wrAddr", 38'(wrASeen), 38'(a));
      check("R6 wrData truncated", 38'(wrDSeen), 38'(pat(a) & expMask(a)));
    end

    // R4/R5/R6/R7/R8/R10: read sweep, each value returned one scan later
    for (int a = 0; a <= 32; a++) begin
      logic [31:0] exp;
      scan(1'b0, (a < 32) ? 5'(a) : 5'd4, 32'hFFFF_FFFF);
      check("R10 read frame no wrStb", 38'(wrSeen), 38'd0);
      if (a > 0) begin
        if (a - 1 == 1) exp = {27'd0, coreStatus};
        else exp = pat(a - 1) & expMask(a - 1);
        check("R4 pipelined read data", capBits, {6'd0, exp});
        check("R8 consume only for address 5", 38'(consumeSeen), 38'(a - 1 == 5));
      end
    end

    // R7: status follows the input, not the write
    coreStatus = 5'h14;
    scan(1'b1, 5'd1, 32'h0000_001F);
    scan(1'b0, 5'd1, 32'h0);
    scan(1'b0, 5'd4, 32'h0);
    check("R7 status from input", capBits, 38'h14);
    check("R8 no consume on control", 38'(consumeSeen), 38'd0);

    // R9: monitor enable set and cleared through debug control
    scan(1'b1, 5'd0, 32'h0000_0010);
    check("R9 monitorEn set", 38'(monSeen), 38'd1);
    scan(1'b1, 5'd0, 32'hFFFF_FFEF);
    check("R9 monitorEn clear", 38'(monSeen), 38'd0);
    scan(1'b0, 5'd0, 32'h0);
    scan(1'b0, 5'd5, 32'h0);
    check("R5 debug control 6 bits", capBits, 38'h2F);
    scan(1'b0, 5'd4, 32'h0);
    check("R8 consume on comms data", 38'(consumeSeen), 38'd1);
    check("R4 comms data read", capBits, {6'd0, pat(5)});

    // R2: idle cycles keep tdo
    begin
      logic t0;
      t0 = tdo;
      repeat (5) @(negedge tck);
      check("R2 tdo idle", 38'(tdo), 38'(t0));
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge tck);
    if (!done) begin
      errs++;
      vecs++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule